// File: doc/BRIEF.md
# External Interrupt Pin Sense and Pending Flags

This block watches four external interrupt pins. Each pin passes through its own synchronizer, and a programmable sense mode picks the condition that sets a pending flag for that pin. The mode is one of low level, falling edge, rising edge or either edge. While its flag is set, a pin raises a request toward the CPU or toward a data-transfer engine, whichever its routing bit selects.

Software reaches two registers through a small register port. The control register holds the sense modes and the routing bits. The status register shows the synchronized pin levels and the pending flags. A flag clears in two ways. One is acceptance: the acknowledge from the destination the pin is routed to. The other is a handshake in which software reads the flag as 1 and then writes 0 to it. A new set condition that arrives after that read cancels the handshake, so an event cannot be lost between the read and the write.

Top module: `xirq_sense`

## Requirements
- R1: After reset all flags are 0, the control register reads 0 and both request outputs are 0.
- R2: Reading address 1 returns the pending flags in bits [3:0] and the synchronized pin levels in bits [7:4]. All other bits read 0.
- R3: Address 0 is the control register. Bits [2n+1:2n] hold the sense mode of pin n and bit 8+n routes pin n to the data-transfer engine when it is 1. A write stores bits [11:0] and reads them back.
- R4: Sense code 00 is low level. The flag sets on every cycle the synchronized pin is low. The request appears three clock edges after the pin changes: two synchronizer stages plus the flag register.
- R5: Sense code 01 is falling edge. A high-to-low change sets the flag and a low-to-high change does not.
- R6: Sense code 10 is rising edge. A low-to-high change sets the flag and a high-to-low change does not.
- R7: Sense code 11 is both edges. Either change sets the flag.
- R8: A pending pin drives cpu_req[n] when its routing bit is 0 and dtc_req[n] when it is 1. Only the acknowledge of the selected destination clears the flag. The other acknowledge has no effect.
- R9: A status read that returns flag n as 1, followed by a status write with bit n = 0, clears flag n.
- R10: A status write with bit n = 0 and no earlier read of the flag as 1 leaves the flag set. A write with bit n = 1 never changes the flag.
- R11: A set condition that occurs between the read and the write cancels the handshake, and the write of 0 then leaves the flag set.
- R12: In low-level mode a software clear has no effect while the pin stays low. After the pin goes high the flag holds until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | 4 | Asynchronous external interrupt pins |
| reg_addr | input | 1 | Register select: 0 = control, 1 = status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a status read arms the clear handshake |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| cpu_ack | input | 4 | Per-pin acceptance from the CPU |
| dtc_ack | input | 4 | Per-pin acceptance from the data-transfer engine |
| cpu_req | output | 4 | Per-pin interrupt request to the CPU |
| dtc_req | output | 4 | Per-pin activation request to the data-transfer engine |

## Verification
The assertions assume that read and write strobes are single-cycle pulses on a stable address. They also assume that an acknowledge goes only to a pin that is requesting. The bench drives every strobe, acknowledge and pin change on the falling clock edge, and it pulses an acknowledge only after it has seen the matching request. Pins change only after the previous condition has had at least four cycles to settle through the synchronizer, so each set event is seen as one distinct edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_FALL = 2'b01,
    SNS_RISE = 2'b10,
    SNS_BOTH = 2'b11
  } sense_e;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dout_d
);
  // stage STAGES holds the previous synchronized sample for edge detection
  logic [STAGES:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '1;
    else        pipe[0] <= din;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[i] <= '1;
      else        pipe[i] <= pipe[i-1];
    end
  end

  assign dout   = pipe[STAGES-1];
  assign dout_d = pipe[STAGES];
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan
  import xirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lvl,
  input  logic   lvl_d,
  input  sense_e sense,
  input  logic   route_dtc,
  input  logic   ack_cpu,
  input  logic   ack_dtc,
  input  logic   rd_stat,
  input  logic   wr_stat,
  input  logic   wr_bit,
  output logic   flag,
  output logic   cpu_req,
  output logic   dtc_req
);
  logic fall, rise, set_ev, accept, sw_clr, armed;
  logic flag_n, armed_n;

  assign fall = lvl_d & ~lvl;
  assign rise = ~lvl_d & lvl;

  always_comb begin
    unique case (sense)
      SNS_LOW:  set_ev = ~lvl;
      SNS_FALL: set_ev = fall;
      SNS_RISE: set_ev = rise;
      default:  set_ev = fall | rise;
    endcase
  end

  assign accept  = route_dtc ? ack_dtc : ack_cpu;
  assign sw_clr  = wr_stat & ~wr_bit & armed;
  // a set in the same cycle wins over any clear
  assign flag_n  = set_ev | (flag & ~(accept | sw_clr));
  assign armed_n = ~set_ev & flag_n & (armed | (rd_stat & flag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag  <= flag_n;
      armed <= armed_n;
    end
  end

  assign cpu_req = flag & ~route_dtc;
  assign dtc_req = flag & route_dtc;

  a_r4_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SNS_LOW && !lvl) |=> flag);
  a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SNS_BOTH && lvl != lvl_d) |=> flag);
  a_r8_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && accept && !set_ev) |=> !flag);
  a_r8_wrong_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !accept && !wr_stat) |=> flag);
  a_r10_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && wr_stat && wr_bit && !accept) |=> flag);
  a_r11_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed && !accept) |=> flag);
endmodule

// File: rtl/xirq_sense.sv
module xirq_sense
  import xirq_pkg::*;
#(
  parameter int unsigned NPINS  = 4,
  parameter int unsigned STAGES = 2,
  parameter int unsigned DW     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] irq_pin,
  input  logic             reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NPINS-1:0] cpu_ack,
  input  logic [NPINS-1:0] dtc_ack,
  output logic [NPINS-1:0] cpu_req,
  output logic [NPINS-1:0] dtc_req
);
  localparam int unsigned CW = 3 * NPINS;
  localparam int unsigned SW = 2 * NPINS;

  logic [CW-1:0]    ctrl_q;
  logic [NPINS-1:0] lvl, lvl_d, flags;
  logic             sel_stat, rd_stat, wr_stat, wr_ctrl;

  assign sel_stat = (reg_addr == 1'(ADDR_STAT));
  assign rd_stat  = reg_rd & sel_stat;
  assign wr_stat  = reg_wr & sel_stat;
  assign wr_ctrl  = reg_wr & ~sel_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wdata[CW-1:0];
  end

  xirq_sync #(.W(NPINS), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_pin), .dout(lvl), .dout_d(lvl_d)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    xirq_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl[n]),
      .lvl_d    (lvl_d[n]),
      .sense    (sense_e'(ctrl_q[2*n +: 2])),
      .route_dtc(ctrl_q[SW + n]),
      .ack_cpu  (cpu_ack[n]),
      .ack_dtc  (dtc_ack[n]),
      .rd_stat  (rd_stat),
      .wr_stat  (wr_stat),
      .wr_bit   (reg_wdata[n]),
      .flag     (flags[n]),
      .cpu_req  (cpu_req[n]),
      .dtc_req  (dtc_req[n])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_stat) reg_rdata[SW-1:0] = {lvl, flags};
    else          reg_rdata[CW-1:0] = ctrl_q;
  end

  if (CW < DW) begin : g_unused
    logic unused_hi;
    assign unused_hi = ^reg_wdata[DW-1:CW];
  end

  a_r3_ctrl_stores: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q == $past(reg_wdata[CW-1:0])));
  a_r8_one_destination: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req & dtc_req) == '0);
endmodule

// File: tb/xirq_sense_tb.sv
`timescale 1ns/1ps
module xirq_sense_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq_pin = 4'hF;
  logic        reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  cpu_ack = '0, dtc_ack = '0;
  logic [3:0]  cpu_req, dtc_req;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  xirq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_ack(cpu_ack), .dtc_ack(dtc_ack), .cpu_req(cpu_req), .dtc_req(dtc_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_wr(input logic a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic ack(input logic [3:0] c, input logic [3:0] d);
    @(negedge clk); cpu_ack = c; dtc_ack = d;
    @(negedge clk); cpu_ack = '0; dtc_ack = '0;
  endtask

  task automatic pin(input int n, input logic v);
    @(negedge clk); irq_pin[n] = v;
    cyc(4);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 cpu_req", 32'(cpu_req), 0);
    check("R1 dtc_req", 32'(dtc_req), 0);
    bus_rd(1'b0, d); check("R1 ctrl", 32'(d), 0);
    bus_rd(1'b1, d); check("R2 status idle", 32'(d), 32'h00F0);
  endtask

  task automatic t_ctrl;
    logic [15:0] d;
    bus_wr(1'b0, 16'hFA5C); bus_rd(1'b0, d);
    check("R3 ctrl readback", 32'(d), 32'h0A5C);
    bus_wr(1'b0, 16'h0000);
    bus_rd(1'b0, d); check("R3 ctrl cleared", 32'(d), 0);
  endtask

  task automatic t_level;
    logic [15:0] d;
    @(negedge clk); irq_pin[2] = 1'b0;
    @(negedge clk); check("R4 latency 1", 32'(cpu_req[2]), 0);
    @(negedge clk); check("R4 latency 2", 32'(cpu_req[2]), 0);
    @(negedge clk); check("R4 latency 3", 32'(cpu_req[2]), 1);
    bus_rd(1'b1, d); check("R2 level+flag", 32'(d), 32'h00B4);
    bus_wr(1'b1, 16'h0000); cyc(1);
    check("R12 clear while low", 32'(cpu_req[2]), 1);
    pin(2, 1'b1);
    check("R12 held after high", 32'(cpu_req[2]), 1);
    bus_rd(1'b1, d); bus_wr(1'b1, 16'h0000);
    check("R9 clear level flag", 32'(cpu_req[2]), 0);
  endtask

  task automatic t_fall;
    bus_wr(1'b0, 16'h0004);
    pin(1, 1'b0); check("R5 falling sets", 32'(cpu_req), 32'h2);
    ack(4'h2, 4'h0); check("R8 cpu ack clears", 32'(cpu_req), 0);
    cyc(3); check("R5 no reset while low", 32'(cpu_req), 0);
    pin(1, 1'b1); check("R5 rising ignored", 32'(cpu_req), 0);
  endtask

  task automatic t_rise;
    bus_wr(1'b0, 16'h0080);
    pin(3, 1'b0); check("R6 falling ignored", 32'(cpu_req), 0);
    pin(3, 1'b1); check("R6 rising sets", 32'(cpu_req), 32'h8);
    ack(4'h8, 4'h0);
  endtask

  task automatic t_both;
    bus_wr(1'b0, 16'h0003);
    pin(0, 1'b0); check("R7 fall sets", 32'(cpu_req), 32'h1);
    ack(4'h1, 4'h0);
    pin(0, 1'b1); check("R7 rise sets", 32'(cpu_req), 32'h1);
    ack(4'h1, 4'h0); check("R7 acked", 32'(cpu_req), 0);
  endtask

  task automatic t_route;
    bus_wr(1'b0, 16'h0103);
    pin(0, 1'b0);
    check("R8 dtc_req", 32'(dtc_req), 32'h1);
    check("R8 no cpu_req", 32'(cpu_req), 0);
    ack(4'h1, 4'h0); check("R8 cpu ack ignored", 32'(dtc_req), 32'h1);
    ack(4'h0, 4'h1); check("R8 dtc ack clears", 32'(dtc_req), 0);
    pin(0, 1'b1); ack(4'h0, 4'h1);
  endtask

  task automatic t_swclr;
    logic [15:0] d;
    bus_wr(1'b0, 16'h0004);
    pin(1, 1'b0);
    bus_wr(1'b1, 16'h0000); check("R10 write0 no read", 32'(cpu_req), 32'h2);
    bus_rd(1'b1, d); check("R9 read sees flag", 32'(d[3:0]), 32'h2);
    bus_wr(1'b1, 16'h000F); check("R10 write1 kept", 32'(cpu_req), 32'h2);
    bus_wr(1'b1, 16'h0000); check("R9 read then write0", 32'(cpu_req), 0);
    pin(1, 1'b1);
    bus_wr(1'b0, 16'h000C);
    pin(1, 1'b0);
    bus_rd(1'b1, d); check("R11 flag read", 32'(d[3:0]), 32'h2);
    pin(1, 1'b1);
    bus_wr(1'b1, 16'h0000); check("R11 new set cancels", 32'(cpu_req), 32'h2);
    bus_rd(1'b1, d); bus_wr(1'b1, 16'h0000);
    check("R11 rearmed clear", 32'(cpu_req), 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_ctrl();
    t_level();
    t_fall();
    t_rise();
    t_both();
    t_route();
    t_swclr();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #400000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule